// File: doc/BRIEF.md
# USB PD Receive Message Parser

This block sits behind the receive FIFO of a USB Power Delivery PHY and rebuilds one received message at a time from the byte stream the FIFO hands out. Every message in the FIFO opens with one marker byte that says which start-of-packet ordered set was seen. Next come the two header bytes, low byte first, then zero to seven 32-bit data objects, then a four-byte CRC. The object count sits in a 3-bit field of the header. The parser uses it to work out how many bytes still belong to the message, so the message length never has to be supplied from outside.

Once the last CRC byte is taken, the header and the received objects are copied into an output buffer and a one-cycle message-valid pulse is raised. The CRC bytes are read and dropped. Object slots above the received count keep the values from an earlier message. If the FIFO stops supplying bytes partway through a message for longer than a programmable number of cycles, the parser gives up on that message. It raises a one-cycle flush request so the FIFO can be cleared, and returns to waiting for a new message.

Top module: `pd_rx_parser`

## Requirements
- R1: After reset, msg_valid_o and flush_req_o are low and hdr_o and every object slot of obj_o read zero.
- R2: While waiting for a new message, the parser asserts rx_ready_o only when rx_empty_i is low, and takes no byte while rx_empty_i is high, even if rx_valid_i is high.
- R3: The first byte of a message is the marker and is discarded. The second byte becomes hdr_o[7:0] and the third becomes hdr_o[15:8].
- R4: The object count n is hdr_o[14:12]. After the header the parser takes exactly 4n+4 bytes and then treats the next byte as the marker of a new message.
- R5: Object k (k = 0..n-1) is built from four consecutive payload bytes, least significant byte first, and appears at obj_o[32k+31:32k].
- R6: The four CRC bytes never appear in obj_o, and object slots k >= n keep their previous contents when a message completes.
- R7: msg_valid_o is high for exactly one cycle, in the cycle after the edge that accepts the last CRC byte. In that same cycle hdr_o and obj_o already show the new message.
- R8: hdr_o and obj_o change only at the completion of a message. They do not change while the next message is being received or after an aborted one.
- R9: Once a message has started, if no byte is accepted for more than timeout_i consecutive cycles, the message is dropped. flush_req_o then pulses for one cycle, msg_valid_o stays low, and the parser goes back to waiting for a marker.
- R10: A gap of exactly timeout_i cycles without a byte inside a message does not abort it. A timeout_i of zero aborts on the first cycle without a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Byte at the head of the receive FIFO |
| rx_valid_i | input | 1 | rx_data_i holds a byte |
| rx_empty_i | input | 1 | Receive FIFO reports empty |
| timeout_i | input | TMO_W | Consecutive byte-less cycles allowed inside a message |
| rx_ready_o | output | 1 | Parser takes the byte when rx_valid_i is high |
| hdr_o | output | 16 | Header of the last completed message |
| obj_o | output | MAX_OBJ*32 | Data objects of the last completed message, slot 0 in the low bits |
| msg_valid_o | output | 1 | One-cycle pulse when a message completes |
| flush_req_o | output | 1 | One-cycle pulse requesting a FIFO flush after an abort |

## Verification
The assertions assume that timeout_i is held steady while a message is in progress. They also assume that rx_valid_i and rx_data_i come from a FIFO head that stays put until it is taken. The stimulus only changes timeout_i between messages, when the parser is idle. It drives bytes one at a time with gaps drawn at random but limited to the current timeout, except in the directed stall cases. The bench also holds rx_valid_i high with rx_empty_i high while the parser is idle. This breaks the usual FIFO rule on purpose, to show that the empty flag alone gates the start of a message.

// File: rtl/pd_rx_pkg.sv
package pd_rx_pkg;
  localparam int OBJ_W    = 32;
  localparam int HDR_W    = 16;
  localparam int CNT_W    = 3;
  localparam int CNT_LSB  = 12;
  localparam int BYTE_W   = 8;
  localparam int LANES    = OBJ_W / BYTE_W;
  localparam int CRC_B    = 4;
  localparam int MAX_FLD  = (1 << CNT_W) - 1;
  localparam int BIDX_W   = $clog2(MAX_FLD * LANES + CRC_B);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR_LO,
    ST_HDR_HI,
    ST_BODY
  } rx_state_e;
endpackage

// File: rtl/pd_rx_stall_timer.sv
module pd_rx_stall_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             beat_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q;

  assign expire_o = active_i && !beat_i && (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!active_i || beat_i || expire_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + TMO_W'(1);
  end

  // stall count never runs past the limit while a message is open
  assert_stall_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !beat_i && $stable(limit_i)) |-> (cnt_q <= limit_i));
endmodule

// File: rtl/pd_rx_fsm.sv
module pd_rx_fsm
  import pd_rx_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_valid_i,
  input  logic                rx_empty_i,
  input  logic [CNT_W-1:0]    cnt_field_i,
  input  logic [TMO_W-1:0]    timeout_i,
  output logic                rx_ready_o,
  output logic                hdr_lo_we_o,
  output logic                hdr_hi_we_o,
  output logic                obj_we_o,
  output logic [CNT_W-1:0]    obj_sel_o,
  output logic [1:0]          lane_o,
  output logic                commit_o,
  output logic                abort_o
);
  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIDX_W-1:0] bidx_q;
  logic [BIDX_W-1:0] pay_bytes, last_idx;
  logic              beat, active, expire;

  assign pay_bytes  = BIDX_W'({cnt_q, 2'b00});
  assign last_idx   = pay_bytes + BIDX_W'(CRC_B - 1);
  assign active     = (state_q != ST_IDLE);
  assign rx_ready_o = active || !rx_empty_i;
  assign beat       = rx_valid_i && rx_ready_o;

  pd_rx_stall_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .beat_i  (beat),
    .limit_i (timeout_i),
    .expire_o(expire)
  );

  assign abort_o     = expire;
  assign hdr_lo_we_o = beat && (state_q == ST_HDR_LO);
  assign hdr_hi_we_o = beat && (state_q == ST_HDR_HI);
  assign obj_we_o    = beat && (state_q == ST_BODY) && (bidx_q < pay_bytes);
  assign obj_sel_o   = bidx_q[BIDX_W-1:2];
  assign lane_o      = bidx_q[1:0];
  assign commit_o    = beat && (state_q == ST_BODY) && (bidx_q == last_idx);

  always_comb begin
    state_d = state_q;
    if (expire) state_d = ST_IDLE;
    else if (beat) begin
      unique case (state_q)
        ST_IDLE:   state_d = ST_HDR_LO;
        ST_HDR_LO: state_d = ST_HDR_HI;
        ST_HDR_HI: state_d = ST_BODY;
        ST_BODY:   if (bidx_q == last_idx) state_d = ST_IDLE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
    end else begin
      state_q <= state_d;
      if (hdr_hi_we_o) begin
        cnt_q  <= cnt_field_i;
        bidx_q <= '0;
      end else if (beat && state_q == ST_BODY) begin
        bidx_q <= bidx_q + BIDX_W'(1);
      end
    end
  end

  assert_body_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BODY) |-> (bidx_q <= last_idx));

  assert_abort_to_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (state_q == ST_IDLE));

  assert_no_commit_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && abort_o));
endmodule

// File: rtl/pd_rx_assembler.sv
module pd_rx_assembler
  import pd_rx_pkg::*;
#(
  parameter int MAX_OBJ = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [BYTE_W-1:0]        data_i,
  input  logic                     hdr_lo_we_i,
  input  logic                     hdr_hi_we_i,
  input  logic                     obj_we_i,
  input  logic [CNT_W-1:0]         obj_sel_i,
  input  logic [1:0]               lane_i,
  output logic [HDR_W-1:0]         hdr_o,
  output logic [MAX_OBJ*OBJ_W-1:0] obj_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hdr_o <= '0;
    else begin
      if (hdr_lo_we_i) hdr_o[7:0]  <= data_i;
      if (hdr_hi_we_i) hdr_o[15:8] <= data_i;
    end
  end

  for (genvar s = 0; s < MAX_OBJ; s++) begin : g_slot
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) obj_o[s*OBJ_W + l*BYTE_W +: BYTE_W] <= '0;
        else if (obj_we_i && obj_sel_i == CNT_W'(s) && lane_i == 2'(l))
          obj_o[s*OBJ_W + l*BYTE_W +: BYTE_W] <= data_i;
      end
    end
  end
endmodule

// File: rtl/pd_rx_msg_buf.sv
module pd_rx_msg_buf
  import pd_rx_pkg::*;
#(
  parameter int MAX_OBJ = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     commit_i,
  input  logic                     abort_i,
  input  logic [HDR_W-1:0]         work_hdr_i,
  input  logic [MAX_OBJ*OBJ_W-1:0] work_obj_i,
  output logic [HDR_W-1:0]         hdr_o,
  output logic [MAX_OBJ*OBJ_W-1:0] obj_o,
  output logic                     msg_valid_o,
  output logic                     flush_req_o
);
  logic [CNT_W-1:0] n;
  assign n = work_hdr_i[CNT_LSB +: CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_o       <= '0;
      msg_valid_o <= 1'b0;
      flush_req_o <= 1'b0;
    end else begin
      msg_valid_o <= commit_i;
      flush_req_o <= abort_i;
      if (commit_i) hdr_o <= work_hdr_i;
    end
  end

  for (genvar s = 0; s < MAX_OBJ; s++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) obj_o[s*OBJ_W +: OBJ_W] <= '0;
      else if (commit_i && (CNT_W'(s) < n)) obj_o[s*OBJ_W +: OBJ_W] <= work_obj_i[s*OBJ_W +: OBJ_W];
    end

    assert_slot_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (msg_valid_o && (hdr_o[CNT_LSB +: CNT_W] <= CNT_W'(s))) |-> $stable(obj_o[s*OBJ_W +: OBJ_W]));
  end

  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |=> !msg_valid_o);

  assert_hdr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_valid_o |-> $stable(hdr_o));

  assert_flush_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(msg_valid_o && flush_req_o));
endmodule

// File: rtl/pd_rx_parser.sv
module pd_rx_parser
  import pd_rx_pkg::*;
#(
  parameter int MAX_OBJ = 7,
  parameter int TMO_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [7:0]               rx_data_i,
  input  logic                     rx_valid_i,
  input  logic                     rx_empty_i,
  input  logic [TMO_W-1:0]         timeout_i,
  output logic                     rx_ready_o,
  output logic [15:0]              hdr_o,
  output logic [MAX_OBJ*32-1:0]    obj_o,
  output logic                     msg_valid_o,
  output logic                     flush_req_o
);
  logic                     hdr_lo_we, hdr_hi_we, obj_we, commit, abort;
  logic [CNT_W-1:0]         obj_sel;
  logic [1:0]               lane;
  logic [HDR_W-1:0]         work_hdr;
  logic [MAX_OBJ*OBJ_W-1:0] work_obj;

  pd_rx_fsm #(.TMO_W(TMO_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_empty_i (rx_empty_i),
    .cnt_field_i(rx_data_i[CNT_LSB-8 +: CNT_W]),
    .timeout_i  (timeout_i),
    .rx_ready_o (rx_ready_o),
    .hdr_lo_we_o(hdr_lo_we),
    .hdr_hi_we_o(hdr_hi_we),
    .obj_we_o   (obj_we),
    .obj_sel_o  (obj_sel),
    .lane_o     (lane),
    .commit_o   (commit),
    .abort_o    (abort)
  );

  pd_rx_assembler #(.MAX_OBJ(MAX_OBJ)) u_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (rx_data_i),
    .hdr_lo_we_i(hdr_lo_we),
    .hdr_hi_we_i(hdr_hi_we),
    .obj_we_i   (obj_we),
    .obj_sel_i  (obj_sel),
    .lane_i     (lane),
    .hdr_o      (work_hdr),
    .obj_o      (work_obj)
  );

  pd_rx_msg_buf #(.MAX_OBJ(MAX_OBJ)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .abort_i    (abort),
    .work_hdr_i (work_hdr),
    .work_obj_i (work_obj),
    .hdr_o      (hdr_o),
    .obj_o      (obj_o),
    .msg_valid_o(msg_valid_o),
    .flush_req_o(flush_req_o)
  );

  assert_empty_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_empty_i && !rx_ready_o) |=> $stable(hdr_o));
endmodule

// File: tb/pd_rx_parser_bench.sv
`timescale 1ns/1ps
module pd_rx_parser_bench;
  localparam int MAX_OBJ = 7;
  localparam int TMO_W   = 8;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [7:0]            rx_data = '0;
  logic                  rx_valid = 1'b0;
  logic                  rx_empty = 1'b1;
  logic [TMO_W-1:0]      tmo = 8'd5;
  logic                  rx_ready;
  logic [15:0]           hdr;
  logic [MAX_OBJ*32-1:0] obj;
  logic                  msg_valid, flush_req;

  int checks = 0, errors = 0;
  int valid_seen = 0, flush_seen = 0;
  logic [15:0] exp_hdr = '0;
  logic [31:0] exp_obj [MAX_OBJ];
  logic [31:0] tx_obj  [MAX_OBJ];

  always #5 clk = ~clk;

  pd_rx_parser #(.MAX_OBJ(MAX_OBJ), .TMO_W(TMO_W)) u_pd_rx_parser (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_empty_i(rx_empty), .timeout_i(tmo), .rx_ready_o(rx_ready), .hdr_o(hdr),
    .obj_o(obj), .msg_valid_o(msg_valid), .flush_req_o(flush_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    if (msg_valid) valid_seen++;
    if (flush_req) flush_seen++;
  endtask

  task automatic push(logic [7:0] b);
    rx_data = b; rx_valid = 1'b1; rx_empty = 1'b0;
    tick();
    rx_valid = 1'b0; rx_empty = 1'b1;
  endtask

  task automatic gap(int k);
    rx_valid = 1'b0; rx_empty = 1'b1;
    for (int i = 0; i < k; i++) tick();
  endtask

  task automatic check_outputs(string req);
    chk(req, 32'(hdr), 32'(exp_hdr));
    for (int s = 0; s < MAX_OBJ; s++) chk(req, obj[s*32 +: 32], exp_obj[s]);
  endtask

  function automatic logic [7:0] obj_byte(int idx);
    return tx_obj[idx/4][(idx%4)*8 +: 8];
  endfunction

  // full message; gaps between bytes drawn in 0..maxgap
  task automatic send_msg(logic [15:0] h, logic [31:0] crc, int maxgap);
    int n;
    int v0, f0;
    n = int'(h[14:12]);
    v0 = valid_seen; f0 = flush_seen;
    push(8'h5A ^ h[7:0]);
    gap(maxgap > 0 ? $urandom_range(maxgap) : 0);
    push(h[7:0]);
    gap(maxgap > 0 ? $urandom_range(maxgap) : 0);
    push(h[15:8]);
    for (int i = 0; i < 4*n + 4; i++) begin
      gap(maxgap > 0 ? $urandom_range(maxgap) : 0);
      if (i == 2) check_outputs("R8");
      push(i < 4*n ? obj_byte(i) : crc[(i-4*n)*8 +: 8]);
    end
    chk("R7", 32'(msg_valid), 32'd1);
    chk("R7", 32'(valid_seen - v0), 32'd1);
    chk("R9", 32'(flush_seen - f0), 32'd0);
    exp_hdr = h;
    for (int s = 0; s < n; s++) exp_obj[s] = tx_obj[s];
    check_outputs("R5");
    tick();
    chk("R7", 32'(msg_valid), 32'd0);
  endtask

  task automatic fill_random();
    for (int s = 0; s < MAX_OBJ; s++) tx_obj[s] = $urandom;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int s = 0; s < MAX_OBJ; s++) exp_obj[s] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1", 32'(msg_valid), 0);
    chk("R1", 32'(flush_req), 0);
    check_outputs("R1");

    // R2: empty gates start even with valid high
    rx_valid = 1'b1; rx_empty = 1'b1; rx_data = 8'hC3;
    #1 chk("R2", 32'(rx_ready), 0);
    for (int i = 0; i < 4; i++) tick();
    rx_valid = 1'b0;
    chk("R2", 32'(flush_seen), 0);
    gap(12);
    chk("R2 idle no flush", 32'(flush_seen), 0);
    // R3/R4: seven objects, header byte order
    fill_random();
    send_msg(16'h7A61, 32'hDEAD_BEEF, 0);
    chk("R3", 32'(hdr[7:0]), 32'h61);
    chk("R3", 32'(hdr[15:8]), 32'h7A);

    // R4/R6: zero objects, slots untouched, CRC not stored
    fill_random();
    send_msg(16'h0F11, 32'hA5A5_A5A5, 0);
    // R6: two objects, upper slots keep older values
    fill_random();
    send_msg(16'h2044, 32'h0BAD_F00D, 0);
    for (int s = 0; s < MAX_OBJ; s++)
      chk("R6 crc not in slot", 32'(obj[s*32 +: 32] == 32'h0BAD_F00D && s >= 2), 0);

    // R4: back-to-back messages, no idle between
    for (int m = 0; m < 3; m++) begin
      fill_random();
      send_msg({1'b0, 3'(m + 3), 12'($urandom)}, $urandom, 0);
    end

    // random messages with gaps up to timeout
    for (int m = 0; m < 60; m++) begin
      fill_random();
      send_msg(16'($urandom), $urandom, int'(tmo));
    end

    // R10: gap of exactly timeout inside a message
    fill_random();
    begin
      int f0;
      f0 = flush_seen;
      push(8'h00); push(8'h34); push(8'h12); // n=1
      gap(int'(tmo));
      push(tx_obj[0][7:0]); push(tx_obj[0][15:8]); push(tx_obj[0][23:16]); push(tx_obj[0][31:24]);
      for (int i = 0; i < 4; i++) push(8'hEE);
      chk("R10", 32'(flush_seen - f0), 0);
      chk("R10", 32'(msg_valid), 1);
      exp_hdr = 16'h1234; exp_obj[0] = tx_obj[0];
      check_outputs("R10");
      tick();
    end

    // R9: gap of timeout+1 aborts
    begin
      int f0, v0;
      f0 = flush_seen; v0 = valid_seen;
      push(8'h00); push(8'h99); push(8'h30); push(8'h11);
      gap(int'(tmo));
      chk("R9 before limit", 32'(flush_seen - f0), 0);
      gap(1);
      chk("R9 flush pulse", 32'(flush_req), 1);
      gap(1);
      chk("R9 flush one cycle", 32'(flush_req), 0);
      chk("R9 no msg", 32'(valid_seen - v0), 0);
      check_outputs("R8 after abort");
      fill_random();
      send_msg(16'h3ABC, 32'h1111_2222, 0);
      chk("R9 single flush", 32'(flush_seen - f0), 1);
    end

    // R10: timeout zero
    tmo = 8'd0;
    tick();
    fill_random();
    send_msg(16'h4001, 32'h5555_6666, 0);
    begin
      int f0;
      f0 = flush_seen;
      push(8'h00); push(8'h01);
      gap(1);
      chk("R10 zero timeout", 32'(flush_seen - f0), 1);
    end
    tmo = 8'd5;
    gap(3);
    fill_random();
    send_msg(16'h1F00, 32'h7777_8888, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule